// File: doc/BRIEF.md
# Video Interrupt Status and NMI Pulse Unit

This block turns the video timing's per-line interrupt events and its vertical-blank event into a non-maskable interrupt request for the CPU. Two single-cycle event inputs arrive from the raster timing. A status register records which event happened last. An enable register decides which event kinds may drive the active-low NMI line. Software reads the status to find out why it was interrupted, and clears it through a write-only clear strobe.

Status bits are recorded whether or not the matching source is enabled, so software can poll the status instead of taking interrupts. The NMI line goes low only on a new, enabled event, and only for a fixed number of cycles. The CPU samples it as an edge, so a CPU that does not look during that window misses the request. Turning an enable on while its status bit is already pending does not raise a late interrupt. A vertical-blank event removes a stale line-interrupt status bit, so the two causes cannot be confused.

Top module: `vnmi_top`

## Requirements
- R1: After reset the status byte reads 0x00, both enables are off, and `nmi_n_o` is high.
- R2: A line event sets status bit 7 on the next cycle even when the line enable (bit 7 of the enable byte) is 0. In that case `nmi_n_o` stays high. Status bits 5..0 always read 0.
- R3: Writing an enable bit while the matching status bit is already set produces no NMI pulse. Only events that arrive after the write can fire.
- R4: An event whose enable bit is set (bit 7 for line events, bit 6 for vertical blank) drives `nmi_n_o` low starting on the cycle after the event.
- R5: With no further enabled event, `nmi_n_o` stays low for exactly PULSE_W cycles (default 8) and then returns high.
- R6: Any cycle with `clr_we_i` high clears both status bits on the next cycle, whatever the write data.
- R7: A vertical-blank event sets status bit 6 and clears status bit 7 on the next cycle.
- R8: If a line event and a vertical-blank event arrive in the same cycle, the status reads 0x40 afterwards.
- R9: An enabled event that arrives while the pulse is active restarts the pulse, so the line stays low for PULSE_W cycles after the last event.
- R10: If a clear strobe and an event arrive in the same cycle, the clear applies first and the event's status bit is still set afterwards.
- R11: An enable write takes effect on the following cycle. An event in the same cycle as the write is gated by the enable value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_evt_i | input | 1 | Single-cycle per-line interrupt event from the raster timing |
| vblank_evt_i | input | 1 | Single-cycle vertical-blank event |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable write data: bit 7 line, bit 6 vertical blank |
| clr_we_i | input | 1 | Write-only status clear strobe |
| stat_o | output | 8 | Status: bit 7 line cause, bit 6 vertical-blank cause, others 0 |
| nmi_n_o | output | 1 | Active-low NMI pulse to the CPU |

## Verification
The bench targets the cases where a naive design raises an interrupt it should not. The first is an event that arrives while its source is disabled: a design that gated status with the enable would lose the polled bit, and a design that ignored the enable would pulse. The second is an enable written while that source's status is pending: a design that derived the NMI from the status AND the enable would fire a late pulse there. The bench also checks pulse length cycle by cycle, restart on a second event, the vertical-blank wipe, simultaneous events, a clear colliding with an event, and an enable write colliding with an event. A wrong length, a merged or dropped pulse, or a wrong status byte in any of these shows up as a mismatch.

// File: rtl/vnmi_pkg.sv
package vnmi_pkg;
    localparam int DATA_W  = 8;
    localparam int N_SRC   = 2;
    // source indices
    localparam int SRC_VBL = 0;
    localparam int SRC_LIN = 1;
    // bit positions shared by enable and status bytes
    localparam int BIT_VBL = 6;
    localparam int BIT_LIN = 7;

    typedef logic [N_SRC-1:0] src_vec_t;

    function automatic int src_bit(input int src);
        return (src == SRC_LIN) ? BIT_LIN : BIT_VBL;
    endfunction
endpackage

// File: rtl/vnmi_enable_reg.sv
module vnmi_enable_reg
    import vnmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output src_vec_t          en_o
);
    typedef struct packed {
        src_vec_t en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            for (int s = 0; s < N_SRC; s++) begin
                st_d.en[s] = wdata_i[src_bit(s)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    assert_en_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (en_o[SRC_LIN] == $past(wdata_i[BIT_LIN])) &&
                 (en_o[SRC_VBL] == $past(wdata_i[BIT_VBL])));
endmodule

// File: rtl/vnmi_status_track.sv
module vnmi_status_track
    import vnmi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_i,
    input  logic     vbl_i,
    input  logic     clr_i,
    output src_vec_t stat_o
);
    typedef struct packed {
        src_vec_t pend;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the clear strobe applies first
        if (clr_i) st_d.pend = '0;
        // events on the same cycle then apply; vertical blank wins
        if (vbl_i) begin
            st_d.pend[SRC_VBL] = 1'b1;
            st_d.pend[SRC_LIN] = 1'b0;
        end else if (line_i) begin
            st_d.pend[SRC_LIN] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.pend;

    assert_vbl_wipes_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_i |=> (stat_o[SRC_VBL] && !stat_o[SRC_LIN]));

    assert_line_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i && !vbl_i) |=> stat_o[SRC_LIN]);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !line_i && !vbl_i) |=> (stat_o == '0));
endmodule

// File: rtl/vnmi_pulse_gen.sv
module vnmi_pulse_gen #(
    parameter int PULSE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic nmi_n_o
);
    localparam int CW = $clog2(PULSE_W + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          low;
    } pg_state_t;

    pg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i)              st_d.cnt = CW'(PULSE_W);
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        st_d.low = fire_i || (st_q.cnt > CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nmi_n_o = ~st_q.low;

    assert_fire_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> !nmi_n_o);

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_n_o && !fire_i) |=> nmi_n_o);
endmodule

// File: rtl/vnmi_top.sv
module vnmi_top
    import vnmi_pkg::*;
#(
    parameter int PULSE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_evt_i,
    input  logic              vblank_evt_i,
    input  logic              en_we_i,
    input  logic [DATA_W-1:0] en_wdata_i,
    input  logic              clr_we_i,
    output logic [DATA_W-1:0] stat_o,
    output logic              nmi_n_o
);
    src_vec_t en, pend, evt, gated;
    logic     fire;

    assign evt[SRC_LIN] = line_evt_i;
    assign evt[SRC_VBL] = vblank_evt_i;

    vnmi_enable_reg i_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (en_we_i),
        .wdata_i (en_wdata_i),
        .en_o    (en)
    );

    vnmi_status_track i_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_evt_i),
        .vbl_i  (vblank_evt_i),
        .clr_i  (clr_we_i),
        .stat_o (pend)
    );

    // only fresh events fire; pending status never feeds the NMI path
    for (genvar s = 0; s < N_SRC; s++) begin : g_gate
        assign gated[s] = evt[s] & en[s];
    end
    assign fire = |gated;

    vnmi_pulse_gen #(.PULSE_W(PULSE_W)) i_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .nmi_n_o (nmi_n_o)
    );

    always_comb begin
        stat_o = '0;
        for (int s = 0; s < N_SRC; s++) begin
            stat_o[src_bit(s)] = pend[s];
        end
    end

    assert_no_late_nmi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_evt_i && !vblank_evt_i && nmi_n_o) |=> nmi_n_o);

    assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[5:0] == 6'd0);
endmodule

// File: tb/test_vnmi_top.sv
module test_vnmi_top;
    localparam int PW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_evt = 1'b0, vbl_evt = 1'b0, en_we = 1'b0, clr_we = 1'b0;
    logic [7:0] en_wdata = 8'h00;
    logic [7:0] stat;
    logic       nmi_n;

    always #5 clk = ~clk;

    vnmi_top #(.PULSE_W(PW)) i_vnmi_top (
        .clk (clk), .rst_n (rst_n),
        .line_evt_i (line_evt), .vblank_evt_i (vbl_evt),
        .en_we_i (en_we), .en_wdata_i (en_wdata), .clr_we_i (clr_we),
        .stat_o (stat), .nmi_n_o (nmi_n)
    );

    typedef struct {
        logic [7:0] stat;
        logic       nmi;
        string      tag;
    } exp_t;
    exp_t q[$];

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // bench model of the requirements
    logic m_lin = 0, m_vbl = 0, m_en_lin = 0, m_en_vbl = 0;
    int   m_cnt = 0;

    task automatic step(input logic ln, input logic vb, input logic ewe,
                        input logic [7:0] ed, input logic clr, input string tag);
        exp_t e;
        logic fire;
        @(negedge clk);
        line_evt = ln; vbl_evt = vb; en_we = ewe; en_wdata = ed; clr_we = clr;
        fire = (ln && m_en_lin) || (vb && m_en_vbl);   // R11: old enable
        if (clr) begin m_lin = 0; m_vbl = 0; end        // R10: clear first
        if (vb) begin m_vbl = 1; m_lin = 0; end         // R7, R8
        else if (ln) m_lin = 1;                         // R2
        if (ewe) begin m_en_lin = ed[7]; m_en_vbl = ed[6]; end
        if (fire) m_cnt = PW;                           // R4, R9
        else if (m_cnt > 0) m_cnt--;                    // R5
        e.stat = {m_lin, m_vbl, 6'b0};
        e.nmi  = (m_cnt == 0);
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0, tag);
    endtask

    // monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (stat !== e.stat || nmi_n !== e.nmi) begin
                    n_bad++;
                    $display("FAIL %s: stat=%h nmi_n=%b expected stat=%h nmi_n=%b",
                             e.tag, stat, nmi_n, e.stat, e.nmi);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle(2, "R1");
        // R2: disabled line event latches status, no pulse
        step(1, 0, 0, 8'h00, 0, "R2");
        idle(3, "R2");
        // R3: enabling with status pending gives no late pulse
        step(0, 0, 1, 8'hC0, 0, "R3");
        idle(4, "R3");
        // R6: clear strobe (data irrelevant)
        step(0, 0, 0, 8'h5A, 1, "R6");
        // R4/R5: enabled pulse and its width
        step(1, 0, 0, 8'h00, 0, "R4");
        idle(PW + 2, "R5");
        // R7: vertical blank wipes line status
        step(0, 1, 0, 8'h00, 0, "R7");
        idle(PW + 2, "R7");
        // R8: simultaneous events
        step(0, 0, 0, 8'h00, 1, "R8");
        step(1, 1, 0, 8'h00, 0, "R8");
        idle(PW + 2, "R8");
        // R9: retrigger during pulse
        step(1, 0, 0, 8'h00, 0, "R9");
        idle(3, "R9");
        step(1, 0, 0, 8'h00, 0, "R9");
        idle(PW + 2, "R9");
        // R10: clear colliding with an event
        step(1, 0, 0, 8'h00, 1, "R10");
        idle(PW + 2, "R10");
        // R11: enable write colliding with an event uses old enable
        step(1, 0, 1, 8'h00, 0, "R11");
        idle(PW + 2, "R11");
        step(0, 1, 0, 8'h00, 0, "R11");
        idle(3, "R11");
        // R11: re-enable then colliding event is still blocked
        step(0, 0, 1, 8'h00, 1, "R11");
        step(0, 1, 1, 8'h40, 0, "R11");
        idle(3, "R11");
        @(posedge clk);
        #3;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule